// File: doc/BRIEF.md
# TAP Session Anomaly Monitor

This block watches a test access port from the side. It samples the test clock and mode-select lines into the system clock domain, runs its own copy of the sixteen-state TAP controller, and reads the instruction register value that the port latches. It does not drive the port. Its job is to judge whether whoever is driving the port looks like a normal tester or like someone probing the chip.

Judging happens in two stages. The first stage is a hard rule check. Loading an opcode the chip does not support, or shifting a data register with the wrong number of bits for the current opcode, marks the session as hostile at once. That mark stays set until power-on reset. The second stage works on sessions that pass the first stage. It builds a feature record for each instruction: the opcode, the cycles spent in Run-Test/Idle and Test-Logic-Reset, the number of mode-select transitions, and whether the record was closed by a port reset. It checks the record against a per-opcode rule table, which stands in for a trained classifier, and gives a pass or fail prediction. The last K predictions are kept in a window. The number of failed predictions in the window is compared with a low threshold and a high threshold, and the result is a 2-bit trust band.

The opcode table and the rule table are flat input vectors. They are expected to be tied to constants or to a configuration register elsewhere in the chip.

Top module: `jtag_session_monitor`

## Requirements
- R1: After power-on reset (rst_ni low) the window is empty, the hostile mark is clear and verdict_o is 2'b00, given thr_lo_i > 0.
- R2: A feature record is evaluated once in each of two cases. The first is on the TCK edge that leaves Update-IR, if a data register update (Update-DR) happened since the previous instruction load. The second is on the edge that enters Test-Logic-Reset while an instruction is open. An instruction load with no data access in between does not evaluate, and the counters keep running.
- R3: An opcode is legal only when bits [7:4] are zero and bit [3:0] of op_valid_i is set. Bits [3:0] are the table index. Leaving Update-IR with an illegal value on instr_i sets the hostile mark.
- R4: Each data scan counts the TCK rising edges taken in Shift-DR. On entry to Update-DR, if this count differs from op_len_i[8*idx+7:8*idx] for the current opcode, the hostile mark is set.
- R5: Once set, the hostile mark holds through port resets. Only rst_ni clears it.
- R6: A record is predicted illegitimate in any of these cases: (Run-Test/Idle cycles + Test-Logic-Reset cycles) > rule_dwell_i[8*idx+:8]; mode-select transitions > rule_tms_i[8*idx+:8]; or the record was closed by entering Test-Logic-Reset while rule_tlr_ok_i[idx] is 0.
- R7: The dwell and transition counters saturate at 255 and clear after each evaluation.
- R8: The window holds the last K predictions. Each evaluation pushes one prediction in and drops the oldest, and m is the number of illegitimate predictions among them.
- R9: verdict_o is 2'b11 if the hostile mark is set or m == K. Otherwise it is 2'b10 if m >= thr_hi_i, 2'b01 if m >= thr_lo_i, and 2'b00 if neither holds.
- R10: verdict_o is registered. It changes on the fourth system clock edge after the TCK rise that causes an evaluation or sets the hostile mark, which is one cycle after the internal update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than TCK |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed test mode select |
| instr_i | input | 8 | Instruction value latched by the observed port |
| op_valid_i | input | 16 | Per-opcode legal bit, indexed by opcode[3:0] |
| op_len_i | input | 128 | Per-opcode expected data shift length, 8 bits per entry |
| rule_dwell_i | input | 128 | Per-opcode dwell limit, 8 bits per entry |
| rule_tms_i | input | 128 | Per-opcode mode-select transition limit, 8 bits per entry |
| rule_tlr_ok_i | input | 16 | Per-opcode permission for a record to end in a port reset |
| thr_lo_i | input | 4 | Low threshold Tl |
| thr_hi_i | input | 4 | High threshold Th |
| verdict_o | output | 2 | Trust band: 00 legitimate, 01 uncertain, 10 likely hostile, 11 hostile |

## Verification
The hardest case to reach from the ports is a verdict that depends on the whole window: every slot full of failed predictions, and then the oldest ones being pushed out. The bench drives complete TAP sequences (instruction load, data scan, idle dwell) in which the idle length decides the prediction. It runs eight failing instructions and then passing ones, and keeps a shadow window so it can check each band as m rises to K and falls again. Saturation is reached with a dwell of 300 idle cycles against a limit of 255. The record closure rule is exercised by loading an instruction twice with no data access in between.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  localparam int NIB_W = 4;
  localparam int CNT_W = 8;
  localparam int OP_W  = 2 * NIB_W;
  localparam int N_OP  = 1 << NIB_W;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    V_LEGIT = 2'b00, V_UNSURE = 2'b01, V_LIKELY = 2'b10, V_ATTACK = 2'b11
  } verdict_e;

  typedef struct packed {
    logic [NIB_W-1:0] op;
    logic [CNT_W-1:0] rti;
    logic [CNT_W-1:0] tlr;
    logic [CNT_W-1:0] tms_n;
    logic             by_tlr;
  } jsm_rec_t;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TLR:     return tms ? TLR    : RTI;
      RTI:     return tms ? SEL_DR : RTI;
      SEL_DR:  return tms ? SEL_IR : CAP_DR;
      CAP_DR:  return tms ? EX1_DR : SHF_DR;
      SHF_DR:  return tms ? EX1_DR : SHF_DR;
      EX1_DR:  return tms ? UPD_DR : PAU_DR;
      PAU_DR:  return tms ? EX2_DR : PAU_DR;
      EX2_DR:  return tms ? UPD_DR : SHF_DR;
      UPD_DR:  return tms ? SEL_DR : RTI;
      SEL_IR:  return tms ? TLR    : CAP_IR;
      CAP_IR:  return tms ? EX1_IR : SHF_IR;
      SHF_IR:  return tms ? EX1_IR : SHF_IR;
      EX1_IR:  return tms ? UPD_IR : PAU_IR;
      PAU_IR:  return tms ? EX2_IR : PAU_IR;
      EX2_IR:  return tms ? UPD_IR : SHF_IR;
      UPD_IR:  return tms ? SEL_DR : RTI;
      default: return TLR;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction
endpackage

// File: rtl/jsm_tap_tracker.sv
module jsm_tap_tracker
  import jsm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tck_i,
  input  logic       tms_i,
  output logic       step_o,
  output logic       tms_o,
  output tap_state_e state_o,
  output tap_state_e next_o
);
  logic [2:0] tck_sync;
  logic [1:0] tms_sync;
  tap_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_sync <= '0;
      tms_sync <= 2'b11;
    end else begin
      tck_sync <= {tck_sync[1:0], tck_i};
      tms_sync <= {tms_sync[0], tms_i};
    end
  end

  assign step_o  = tck_sync[1] & ~tck_sync[2];
  assign tms_o   = tms_sync[1];
  assign next_o  = tap_next(state_q, tms_sync[1]);
  assign state_o = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= TLR;
    else if (step_o) state_q <= next_o;
  end

  p_state_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |=> $stable(state_q)) else $error("tap state moved without TCK edge");
endmodule

// File: rtl/jsm_feature.sv
module jsm_feature
  import jsm_pkg::*;
#(
  parameter logic [OP_W-1:0] RESET_OP = OP_W'(1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  step_i,
  input  logic                  tms_i,
  input  tap_state_e            state_i,
  input  tap_state_e            next_i,
  input  logic [OP_W-1:0]       instr_i,
  input  logic [N_OP-1:0]       op_valid_i,
  input  logic [N_OP*CNT_W-1:0] op_len_i,
  input  logic [N_OP*CNT_W-1:0] rule_dwell_i,
  input  logic [N_OP*CNT_W-1:0] rule_tms_i,
  input  logic [N_OP-1:0]       rule_tlr_ok_i,
  output logic                  eval_o,
  output logic                  pred_o,
  output logic                  flag_o
);
  logic [OP_W-1:0]  op_q;
  logic             open_q, dr_seen_q, tms_prev_q, flag_q;
  logic [CNT_W-1:0] dr_cnt_q, rti_q, tlr_q, tms_q;

  logic leave_uir, enter_tlr, enter_udr, new_legal, len_bad;
  logic [CNT_W-1:0] exp_len, lim_dwell, lim_tms;
  logic [CNT_W:0]   dwell;
  jsm_rec_t rec;

  assign leave_uir = step_i && (state_i == UPD_IR);
  assign enter_tlr = step_i && (next_i == TLR) && (state_i != TLR);
  assign enter_udr = step_i && (next_i == UPD_DR);
  assign new_legal = (instr_i[OP_W-1:NIB_W] == '0) && op_valid_i[instr_i[NIB_W-1:0]];
  assign exp_len   = op_len_i[op_q[NIB_W-1:0]*CNT_W +: CNT_W];
  assign len_bad   = enter_udr && (dr_cnt_q != exp_len);

  always_comb begin
    rec.op     = op_q[NIB_W-1:0];
    rec.rti    = rti_q;
    rec.tlr    = tlr_q;
    rec.tms_n  = tms_q;
    rec.by_tlr = enter_tlr;
  end

  assign lim_dwell = rule_dwell_i[rec.op*CNT_W +: CNT_W];
  assign lim_tms   = rule_tms_i[rec.op*CNT_W +: CNT_W];
  assign dwell     = {1'b0, rec.rti} + {1'b0, rec.tlr};

  assign eval_o = open_q && ((leave_uir && dr_seen_q) || enter_tlr);
  assign pred_o = (dwell > {1'b0, lim_dwell}) || (rec.tms_n > lim_tms) ||
                  (rec.by_tlr && !rule_tlr_ok_i[rec.op]);
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= RESET_OP;
      open_q     <= 1'b0;
      dr_seen_q  <= 1'b0;
      tms_prev_q <= 1'b1;
      dr_cnt_q   <= '0;
      rti_q      <= '0;
      tlr_q      <= '0;
      tms_q      <= '0;
    end else if (step_i) begin
      if (state_i == RTI) rti_q <= sat_inc(rti_q);
      if (state_i == TLR) tlr_q <= sat_inc(tlr_q);
      if (tms_i != tms_prev_q) tms_q <= sat_inc(tms_q);
      tms_prev_q <= tms_i;
      if (next_i == CAP_DR)       dr_cnt_q <= '0;
      else if (state_i == SHF_DR) dr_cnt_q <= sat_inc(dr_cnt_q);
      if (enter_udr) dr_seen_q <= 1'b1;
      if (leave_uir) begin
        op_q      <= instr_i;
        open_q    <= 1'b1;
        dr_seen_q <= 1'b0;
      end
      if (enter_tlr) begin
        op_q      <= RESET_OP;
        open_q    <= 1'b0;
        dr_seen_q <= 1'b0;
      end
      // closing a record restarts its counters
      if (eval_o) begin
        rti_q <= '0;
        tlr_q <= '0;
        tms_q <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               flag_q <= 1'b0;
    else if ((leave_uir && !new_legal) || len_bad) flag_q <= 1'b1;
  end

  p_flag_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q) else $error("hostile mark cleared");
  p_illegal_op_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_uir && !new_legal) |=> flag_q) else $error("illegal opcode missed");
  p_len_check_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_bad |=> flag_q) else $error("shift length mismatch missed");
  p_rti_cap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && state_i == RTI && rti_q == '1 && !eval_o) |=> rti_q == '1)
    else $error("dwell counter wrapped");
endmodule

// File: rtl/jsm_window.sv
module jsm_window
  import jsm_pkg::*;
#(
  parameter int K  = 8,
  parameter int CW = $clog2(K + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eval_i,
  input  logic          pred_i,
  input  logic          flag_i,
  input  logic [CW-1:0] thr_lo_i,
  input  logic [CW-1:0] thr_hi_i,
  output verdict_e      verdict_o
);
  localparam logic [CW-1:0] K_C = CW'(K);

  logic [K-1:0]  win_q;
  logic [CW-1:0] m_q;
  verdict_e      verdict_q, grade;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      m_q   <= '0;
    end else if (eval_i) begin
      win_q <= {win_q[K-2:0], pred_i};
      m_q   <= m_q + CW'(pred_i) - CW'(win_q[K-1]);
    end
  end

  always_comb begin
    if (m_q == K_C)           grade = V_ATTACK;
    else if (m_q >= thr_hi_i) grade = V_LIKELY;
    else if (m_q >= thr_lo_i) grade = V_UNSURE;
    else                      grade = V_LEGIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) verdict_q <= V_LEGIT;
    else         verdict_q <= flag_i ? V_ATTACK : grade;
  end

  assign verdict_o = verdict_q;

  p_count_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(m_q) == $countones(win_q)) else $error("running count drifted");
  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |=> $stable(m_q)) else $error("count moved without evaluation");
  p_full_window_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_q == K_C) |=> verdict_q == V_ATTACK) else $error("full window not graded hostile");
endmodule

// File: rtl/jtag_session_monitor.sv
module jtag_session_monitor
  import jsm_pkg::*;
#(
  parameter int               K        = 8,
  parameter logic [OP_W-1:0]  RESET_OP = OP_W'(1),
  parameter int               CW       = $clog2(K + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tck_i,
  input  logic                  tms_i,
  input  logic [OP_W-1:0]       instr_i,
  input  logic [N_OP-1:0]       op_valid_i,
  input  logic [N_OP*CNT_W-1:0] op_len_i,
  input  logic [N_OP*CNT_W-1:0] rule_dwell_i,
  input  logic [N_OP*CNT_W-1:0] rule_tms_i,
  input  logic [N_OP-1:0]       rule_tlr_ok_i,
  input  logic [CW-1:0]         thr_lo_i,
  input  logic [CW-1:0]         thr_hi_i,
  output logic [1:0]            verdict_o
);
  logic       step, tms_s, eval, pred, flag;
  tap_state_e state, next;
  verdict_e   verdict;

  jsm_tap_tracker u_tap (
    .clk_i, .rst_ni, .tck_i, .tms_i,
    .step_o(step), .tms_o(tms_s), .state_o(state), .next_o(next)
  );

  jsm_feature #(.RESET_OP(RESET_OP)) u_feat (
    .clk_i, .rst_ni, .step_i(step), .tms_i(tms_s), .state_i(state), .next_i(next),
    .instr_i, .op_valid_i, .op_len_i, .rule_dwell_i, .rule_tms_i, .rule_tlr_ok_i,
    .eval_o(eval), .pred_o(pred), .flag_o(flag)
  );

  jsm_window #(.K(K), .CW(CW)) u_win (
    .clk_i, .rst_ni, .eval_i(eval), .pred_i(pred), .flag_i(flag),
    .thr_lo_i, .thr_hi_i, .verdict_o(verdict)
  );

  assign verdict_o = verdict;

  p_mark_forces_hostile_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag |=> verdict_o == 2'b11) else $error("hostile mark not reflected");
endmodule

// File: tb/jtag_session_monitor_tb.sv
module jtag_session_monitor_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tck = 1'b0;
  logic         tms = 1'b1;
  logic [7:0]   instr = 8'h01;
  logic [15:0]  op_valid = 16'h001E;
  logic [127:0] op_len = '0, rule_dwell = '0, rule_tms = '0;
  logic [15:0]  rule_tlr_ok = 16'hFFEF;
  logic [3:0]   thr_lo = 4'd2, thr_hi = 4'd5;
  logic [1:0]   verdict;
  int checks = 0, errors = 0;

  bit win_m [8];
  bit flag_m;
  bit pend_v, pend_p;

  always #10 clk = ~clk;

  jtag_session_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tck_i(tck), .tms_i(tms), .instr_i(instr),
    .op_valid_i(op_valid), .op_len_i(op_len), .rule_dwell_i(rule_dwell),
    .rule_tms_i(rule_tms), .rule_tlr_ok_i(rule_tlr_ok),
    .thr_lo_i(thr_lo), .thr_hi_i(thr_hi), .verdict_o(verdict)
  );

  function automatic logic [1:0] exp_v();
    int m = 0;
    for (int i = 0; i < 8; i++) m += int'(win_m[i]);
    if (flag_m || m == 8)    return 2'b11;
    if (m >= int'(thr_hi))   return 2'b10;
    if (m >= int'(thr_lo))   return 2'b01;
    return 2'b00;
  endfunction

  task automatic mdl_push(input bit p);
    for (int i = 7; i > 0; i--) win_m[i] = win_m[i-1];
    win_m[0] = p;
  endtask

  task automatic chk(input logic [1:0] exp, input string tag);
    repeat (4) @(negedge clk);
    checks++;
    if (verdict !== exp) begin
      errors++;
      $display("FAIL %s verdict=%0d expected=%0d", tag, verdict, exp);
    end
  endtask

  task automatic tck_cycle(input logic b);
    tms = b;
    repeat (3) @(negedge clk);
    tck = 1'b1;
    repeat (3) @(negedge clk);
    tck = 1'b0;
  endtask

  task automatic tap_reset();
    repeat (5) tck_cycle(1'b1);
    tck_cycle(1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tck_cycle(1'b0);
  endtask

  task automatic load_ir(input logic [7:0] op);
    tck_cycle(1); tck_cycle(1); tck_cycle(0); tck_cycle(0);
    idle(3);
    tck_cycle(1); tck_cycle(1);
    instr = op;
    tck_cycle(0);
  endtask

  task automatic dr_scan(input int n);
    tck_cycle(1); tck_cycle(0); tck_cycle(0);
    idle(n - 1);
    tck_cycle(1); tck_cycle(1); tck_cycle(0);
  endtask

  task automatic run_instr(input logic [7:0] op, input int len, input int idle_n, input bit p);
    load_ir(op);
    if (pend_v) mdl_push(pend_p);
    dr_scan(len);
    idle(idle_n);
    pend_v = 1'b1;
    pend_p = p;
  endtask

  task automatic do_reset(input logic [3:0] lo, input logic [3:0] hi);
    rst_n = 1'b0;
    tck = 1'b0;
    tms = 1'b1;
    thr_lo = lo;
    thr_hi = hi;
    for (int i = 0; i < 8; i++) win_m[i] = 1'b0;
    flag_m = 1'b0;
    pend_v = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    tap_reset();
  endtask

  // R1, R2, R6, R8, R9: clean session then a ramp of failing records
  task automatic t_window();
    do_reset(4'd2, 4'd5);
    chk(2'b00, "R1 reset verdict");
    for (int i = 0; i < 5; i++) begin
      run_instr(8'h01, 32, 2, 1'b0);
      chk(exp_v(), "R6 good records stay legitimate");
    end
    for (int i = 0; i < 8; i++) begin
      run_instr(8'h01, 32, 30, 1'b1);
      chk(exp_v(), $sformatf("R9 band during ramp step %0d", i));
    end
    run_instr(8'h01, 32, 2, 1'b0);
    chk(2'b11, "R9 full window m==K hostile");
    for (int i = 0; i < 4; i++) begin
      run_instr(8'h01, 32, 2, 1'b0);
      chk(exp_v(), $sformatf("R8 oldest prediction drops step %0d", i));
    end
  endtask

  // R6: transition limit per opcode
  task automatic t_tms_rule();
    do_reset(4'd1, 4'd2);
    run_instr(8'h02, 1, 2, 1'b1);
    run_instr(8'h01, 32, 2, 1'b0);
    chk(exp_v(), "R6 transition limit exceeded");
    chk(2'b01, "R6 transition limit gives uncertain");
  endtask

  // R2, R6: port reset closes a record; load without data access does not
  task automatic t_closure();
    do_reset(4'd1, 4'd2);
    run_instr(8'h04, 16, 2, 1'b0);
    tck_cycle(1); tck_cycle(1); tck_cycle(1);
    mdl_push(1'b1);
    pend_v = 1'b0;
    chk(2'b01, "R2 R6 record closed by port reset not permitted");
    do_reset(4'd1, 4'd2);
    load_ir(8'h01);
    idle(30);
    load_ir(8'h01);
    chk(2'b00, "R2 load without data access does not evaluate");
    dr_scan(32);
    load_ir(8'h01);
    chk(2'b01, "R2 accumulated dwell evaluated after data access");
  endtask

  // R7: saturated dwell equals limit 255 and passes
  task automatic t_saturate();
    do_reset(4'd1, 4'd2);
    run_instr(8'h03, 8, 2, 1'b0);
    run_instr(8'h03, 8, 300, 1'b0);
    run_instr(8'h03, 8, 2, 1'b0);
    chk(2'b00, "R7 counter saturates at 255");
  endtask

  // R3, R5, R10: illegal opcode with exact timing, stickiness
  task automatic t_illegal();
    do_reset(4'd2, 4'd5);
    tck_cycle(1); tck_cycle(1); tck_cycle(0); tck_cycle(0);
    idle(3);
    tck_cycle(1); tck_cycle(1);
    instr = 8'h07;
    tms = 1'b0;
    repeat (3) @(negedge clk);
    tck = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (verdict !== 2'b00) begin
      errors++;
      $display("FAIL R10 verdict early=%0d expected=%0d", verdict, 2'b00);
    end
    @(negedge clk);
    checks++;
    if (verdict !== 2'b11) begin
      errors++;
      $display("FAIL R10 R3 verdict on fourth edge=%0d expected=%0d", verdict, 2'b11);
    end
    tck = 1'b0;
    flag_m = 1'b1;
    tap_reset();
    chk(2'b11, "R5 mark survives port reset");
    do_reset(4'd2, 4'd5);
    chk(2'b00, "R5 power-on reset clears mark");
    load_ir(8'h11);
    chk(2'b11, "R3 nonzero upper nibble illegal");
  endtask

  // R4: data shift length against table
  task automatic t_length();
    do_reset(4'd2, 4'd5);
    load_ir(8'h03);
    dr_scan(8);
    chk(2'b00, "R4 matching length accepted");
    dr_scan(7);
    chk(2'b11, "R4 short shift flagged");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      rule_dwell[i*8 +: 8] = 8'd20;
      rule_tms[i*8 +: 8]   = 8'd14;
    end
    op_len[1*8 +: 8] = 8'd32;
    op_len[2*8 +: 8] = 8'd1;
    op_len[3*8 +: 8] = 8'd8;
    op_len[4*8 +: 8] = 8'd16;
    rule_tms[2*8 +: 8]   = 8'd5;
    rule_dwell[3*8 +: 8] = 8'd255;
    t_window();
    t_tms_rule();
    t_closure();
    t_saturate();
    t_illegal();
    t_length();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired verdict=%0d expected=done", verdict);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule